// File: doc/BRIEF.md
# Functional Unit Pool with First-Free Dispatch

This block is a pool of identical execution units that sit behind one shared instruction bus. An instruction on the bus has an opcode, two operands and a tag. The tag is the program line number of the instruction. Each cycle, the idle unit with the lowest index takes the offered instruction. When every unit is busy, the bus stalls and the producer holds the instruction until a unit frees up.

Most operations finish in a single cycle. A multiply runs as a serial add-and-shift loop that handles one multiplier bit per cycle. Units therefore finish at different times, and results leave the pool in completion order, not issue order. A single result port carries each result together with its tag. When several units hold results at once, the port serves them lowest index first. A unit that is not served keeps its result and stays busy. Dependency tracking and register writeback are handled outside the block.

Top module: `fu_pool`

## Requirements
- R1: While reset is applied, and once the synchronised reset has released, `res_valid` is low. After release, `issue_ready` is high.
- R2: Opcode encodings are 0 add, 1 subtract (a−b), 2 shift left, 3 logical shift right, 6 AND, 7 OR and 8 XOR. Results wrap at the data width. The result appears in the cycle right after the capture edge.
- R3: Opcode 4 rotates a left and opcode 5 rotates a right. The shift and rotate amount is the low log2(DATA_W) bits of b, and the upper bits of b are ignored.
- R4: Opcode 9 multiplies using one add-and-shift step per cycle. It returns the low DATA_W bits of a×b, DATA_W+1 cycles after the capture edge.
- R5: Opcodes 10 to 15 are undefined. They return zero with single-cycle timing.
- R6: Every result is presented with the tag of the instruction that produced it.
- R7: At most one unit captures per cycle. The unit that captures is the lowest-indexed idle unit.
- R8: While all units are busy, `issue_ready` is low and nothing is captured. The held instruction is taken, with its operands unchanged, once a unit frees.
- R9: A single-cycle instruction issued after a multiply can deliver its result before the multiply does.
- R10: When several units hold results, the lowest-indexed one is served. The others keep their results until they are served.
- R11: Each accepted instruction yields exactly one result, shown for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | Instruction offered on the bus |
| issue_op | input | 4 | Opcode |
| issue_a | input | DATA_W | First operand |
| issue_b | input | DATA_W | Second operand or shift amount |
| issue_id | input | ID_W | Line-number tag |
| issue_ready | output | 1 | A unit is idle; the offered instruction is taken at this edge |
| res_valid | output | 1 | Result port holds a result |
| res_data | output | DATA_W | Result value |
| res_id | output | ID_W | Tag of the result |

## Verification
A single-cycle operation has its result on the port at the first falling edge after the capture edge. A multiply has its result there at the (DATA_W+1)-th falling edge. The bench drives and samples only on falling edges, counts those edges after each issue, and compares the count to the latency the opcode calls for. When several instructions are in flight, the bench waits a fixed window long enough for all of them to drain. It then compares the order in which tags arrived against the order worked out from those latencies and the lowest-index rule.

// File: rtl/fu_pool_pkg.sv
package fu_pool_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_SHL = 4'd2,
    OP_SHR = 4'd3,
    OP_ROL = 4'd4,
    OP_ROR = 4'd5,
    OP_AND = 4'd6,
    OP_OR  = 4'd7,
    OP_XOR = 4'd8,
    OP_MUL = 4'd9
  } fu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DONE = 2'd2
  } fu_state_e;
endpackage

// File: rtl/fu_rst_sync.sv
module fu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign run_n = sync_q[1];
endmodule

// File: rtl/fu_pick.sv
// Fixed-priority chain: bit 0 is nearest the head of the chain.
module fu_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic blocked;

  always_comb begin
    blocked = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i]  = en & req[i] & ~blocked;
      blocked = blocked | req[i];
    end
  end

  assign any = |req;
endmodule

// File: rtl/fu_alu.sv
module fu_alu
  import fu_pool_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]     sh;
  logic [2*DATA_W-1:0] rot_l;
  logic [2*DATA_W-1:0] rot_r;

  assign sh    = b[SH_W-1:0];
  assign rot_l = {a, a} << sh;
  assign rot_r = {a, a} >> sh;

  always_comb begin
    case (fu_op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_SHL:  y = a << sh;
      OP_SHR:  y = a >> sh;
      OP_ROL:  y = rot_l[2*DATA_W-1:DATA_W];
      OP_ROR:  y = rot_r[DATA_W-1:0];
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/fu_unit.sv
module fu_unit
  import fu_pool_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              grant_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [DATA_W-1:0] res_o,
  output logic [ID_W-1:0]   id_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  fu_state_e         state_q, state_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] mcand_q, mcand_d;
  logic [DATA_W-1:0] mplier_q, mplier_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] step;
  logic              cap_en;

  fu_alu #(.DATA_W(DATA_W)) u_alu (
    .op (op_i),
    .a  (a_i),
    .b  (b_i),
    .y  (alu_y)
  );

  assign cap_en = cap_i && (state_q == ST_IDLE);
  assign step   = mplier_q[0] ? mcand_q : '0;

  always_comb begin
    state_d  = state_q;
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    cnt_d    = cnt_q;
    res_d    = res_q;
    case (state_q)
      ST_IDLE: begin
        if (cap_en) begin
          if (fu_op_e'(op_i) == OP_MUL) begin
            state_d  = ST_MUL;
            acc_d    = '0;
            mcand_d  = a_i;
            mplier_d = b_i;
            cnt_d    = CNT_W'(DATA_W);
          end else begin
            state_d = ST_DONE;
            res_d   = alu_y;
          end
        end
      end
      ST_MUL: begin
        acc_d    = acc_q + step;
        mcand_d  = mcand_q << 1;
        mplier_d = mplier_q >> 1;
        cnt_d    = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          res_d   = acc_q + step;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (grant_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      res_q    <= '0;
    end else begin
      state_q  <= state_d;
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      cnt_q    <= cnt_d;
      res_q    <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      id_q <= '0;
    else if (cap_en) id_q <= id_i;
  end

  assign idle_o = (state_q == ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign res_o  = res_q;
  assign id_o   = id_q;
endmodule

// File: rtl/fu_pool.sv
module fu_pool
  import fu_pool_pkg::*;
#(
  parameter int NUM_FU = 4,
  parameter int DATA_W = 16,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [3:0]        issue_op,
  input  logic [DATA_W-1:0] issue_a,
  input  logic [DATA_W-1:0] issue_b,
  input  logic [ID_W-1:0]   issue_id,
  output logic              issue_ready,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [ID_W-1:0]   res_id
);
  logic              run_n;
  logic              idle_any;
  logic [NUM_FU-1:0] fu_idle;
  logic [NUM_FU-1:0] fu_done;
  logic [NUM_FU-1:0] fu_cap;
  logic [NUM_FU-1:0] fu_grant;
  logic [DATA_W-1:0] fu_res [NUM_FU];
  logic [ID_W-1:0]   fu_id  [NUM_FU];

  fu_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  fu_pick #(.N(NUM_FU)) u_dispatch (
    .req (fu_idle),
    .en  (issue_valid & run_n),
    .gnt (fu_cap),
    .any (idle_any)
  );

  fu_pick #(.N(NUM_FU)) u_result_arb (
    .req (fu_done),
    .en  (1'b1),
    .gnt (fu_grant),
    .any (res_valid)
  );

  assign issue_ready = idle_any & run_n;

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    fu_unit #(.DATA_W(DATA_W), .ID_W(ID_W)) u_fu (
      .clk     (clk),
      .rst_n   (run_n),
      .cap_i   (fu_cap[g]),
      .op_i    (issue_op),
      .a_i     (issue_a),
      .b_i     (issue_b),
      .id_i    (issue_id),
      .grant_i (fu_grant[g]),
      .idle_o  (fu_idle[g]),
      .done_o  (fu_done[g]),
      .res_o   (fu_res[g]),
      .id_o    (fu_id[g])
    );
  end

  always_comb begin
    res_data = '0;
    res_id   = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (fu_grant[i]) begin
        res_data = res_data | fu_res[i];
        res_id   = res_id | fu_id[i];
      end
    end
  end
endmodule

// File: rtl/fu_pool_chk.sv
module fu_pool_chk #(
  parameter int N    = 4,
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic            issue_ready,
  input logic            res_valid,
  input logic [ID_W-1:0] res_id,
  input logic [N-1:0]    idle,
  input logic [N-1:0]    done,
  input logic [N-1:0]    cap,
  input logic [N-1:0]    grant
);
  // R7
  one_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap));

  // R7
  first_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap != '0) |-> (((cap & ~idle) == '0) && ((idle & (cap - 1'b1)) == '0)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |-> (cap == '0));

  // R8
  busy_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap != '0) |=> ((idle & $past(cap)) == '0));

  // R10
  held_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ~grant) != '0) |=> (($past(done & ~grant) & ~done) == '0));

  // R10
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($onehot(grant) && ((grant & ~done) == '0)));

  // R6
  tag_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !$isunknown(res_id));
endmodule

bind fu_pool fu_pool_chk #(.N(NUM_FU), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .res_valid   (res_valid),
  .res_id      (res_id),
  .idle        (fu_idle),
  .done        (fu_done),
  .cap         (fu_cap),
  .grant       (fu_grant)
);

// File: tb/fu_pool_tb.sv
`timescale 1ns/1ps
module fu_pool_tb;
  localparam int NFU = 4;
  localparam int W   = 16;
  localparam int IW  = 8;
  localparam int NV  = 18;

  typedef struct packed {
    logic [3:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] y;
  } vec_t;

  // op, a, b, expected
  localparam vec_t VEC [NV] = '{
    '{4'd0,  16'h1234, 16'h0F0F, 16'h2143},   // R2 add
    '{4'd0,  16'hFFFF, 16'h0002, 16'h0001},   // R2 add wrap
    '{4'd1,  16'h0005, 16'h0007, 16'hFFFE},   // R2 sub
    '{4'd2,  16'h8001, 16'h0001, 16'h0002},   // R2 shl
    '{4'd3,  16'h8001, 16'h0004, 16'h0800},   // R2 shr
    '{4'd4,  16'h8001, 16'h0001, 16'h0003},   // R3 rol
    '{4'd5,  16'h8001, 16'h0004, 16'h1800},   // R3 ror
    '{4'd2,  16'h0001, 16'h0013, 16'h0008},   // R3 upper b ignored
    '{4'd4,  16'h1234, 16'h0000, 16'h1234},   // R3 rotate by zero
    '{4'd6,  16'hF0F0, 16'h3C3C, 16'h3030},   // R2 and
    '{4'd7,  16'hF0F0, 16'h0F01, 16'hFFF1},   // R2 or
    '{4'd8,  16'hAAAA, 16'hFFFF, 16'h5555},   // R2 xor
    '{4'd9,  16'h0007, 16'h0009, 16'h003F},   // R4 mul
    '{4'd9,  16'h0100, 16'h0100, 16'h0000},   // R4 mul overflow
    '{4'd9,  16'hFFFF, 16'hFFFF, 16'h0001},   // R4 mul max
    '{4'd9,  16'h0123, 16'h0000, 16'h0000},   // R4 mul by zero
    '{4'd12, 16'h1234, 16'h5678, 16'h0000},   // R5 undefined
    '{4'd15, 16'hFFFF, 16'hFFFF, 16'h0000}    // R5 undefined
  };

  logic          clk;
  logic          rst_n;
  logic          in_vld;
  logic [3:0]    in_op;
  logic [W-1:0]  in_a;
  logic [W-1:0]  in_b;
  logic [IW-1:0] in_id;
  logic          issue_ready;
  logic          res_valid;
  logic [W-1:0]  res_data;
  logic [IW-1:0] res_id;

  int nvec;
  int nmis;
  int log_n;
  logic [IW-1:0] log_id  [32];
  logic [W-1:0]  log_dat [32];

  fu_pool #(.NUM_FU(NFU), .DATA_W(W), .ID_W(IW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (in_vld),
    .issue_op    (in_op),
    .issue_a     (in_a),
    .issue_b     (in_b),
    .issue_id    (in_id),
    .issue_ready (issue_ready),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_id      (res_id)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial log_n = 0;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && res_valid === 1'b1 && log_n < 32) begin
      log_id[log_n]  <= res_id;
      log_dat[log_n] <= res_data;
      log_n          <= log_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Starts and ends on a falling edge; returns after the capture edge.
  task automatic issue(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [IW-1:0] id);
    in_op  = op;
    in_a   = a;
    in_b   = b;
    in_id  = id;
    in_vld = 1'b1;
    while (issue_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    int base;
    int lat;
    nvec   = 0;
    nmis   = 0;
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_op  = '0;
    in_a   = '0;
    in_b   = '0;
    in_id  = '0;
    repeat (3) @(negedge clk);
    chk("R1 res_valid in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 issue_ready after reset", 32'(issue_ready), 32'd1);
    chk("R1 res_valid after reset", 32'(res_valid), 32'd0);

    // Table walk: one instruction at a time, latency counted in falling edges
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].a, VEC[i].b, IW'(8'h10 + i));
      in_vld = 1'b0;
      lat = 1;
      while (res_valid !== 1'b1 && lat < 64) begin
        @(negedge clk);
        lat++;
      end
      chk($sformatf("R2/R3/R4/R5 data vec %0d", i), 32'(res_data), 32'(VEC[i].y));
      chk($sformatf("R6 tag vec %0d", i), 32'(res_id), 32'(8'h10 + i));
      chk($sformatf("R2/R4 latency vec %0d", i), 32'(lat),
          (VEC[i].op == 4'd9) ? 32'(W + 1) : 32'd1);
      @(negedge clk);
      chk($sformatf("R11 single pulse vec %0d", i), 32'(res_valid), 32'd0);
    end

    // R9: later single-cycle op overtakes an earlier multiply
    base = log_n;
    issue(4'd9, 16'd7, 16'd3, 8'h50);
    issue(4'd0, 16'd1, 16'd1, 8'h51);
    in_vld = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 count", 32'(log_n - base), 32'd2);
    chk("R9 first tag", 32'(log_id[base]), 32'h51);
    chk("R9 first data", 32'(log_dat[base]), 32'd2);
    chk("R9 second tag", 32'(log_id[base+1]), 32'h50);
    chk("R9 second data", 32'(log_dat[base+1]), 32'd21);

    // R8/R10: fill every unit, hold one more, watch the drain order
    base = log_n;
    for (int k = 0; k < NFU; k++) issue(4'd9, W'(k + 1), 16'd3, IW'(8'h40 + k));
    chk("R8 ready low when all busy", 32'(issue_ready), 32'd0);
    chk("R8 no result while all busy", 32'(res_valid), 32'd0);
    issue(4'd0, 16'h0100, 16'h0001, 8'h44);
    in_vld = 1'b0;
    repeat (40) @(negedge clk);
    chk("R11 one result each", 32'(log_n - base), 32'd5);
    chk("R10 order 0", 32'(log_id[base]),   32'h40);
    chk("R10 order 1", 32'(log_id[base+1]), 32'h41);
    chk("R10 lowest index wins tie", 32'(log_id[base+2]), 32'h44);
    chk("R10 held result 2", 32'(log_id[base+3]), 32'h42);
    chk("R10 held result 3", 32'(log_id[base+4]), 32'h43);
    chk("R8 held instruction data", 32'(log_dat[base+2]), 32'h0101);
    chk("R10 held data 2", 32'(log_dat[base+3]), 32'd9);
    chk("R10 held data 3", 32'(log_dat[base+4]), 32'd12);
    chk("R7 all idle again", 32'(issue_ready), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule